// File: doc/BRIEF.md
# Hub Configuration Registers with Power-On Delay

This block holds the small set of configuration and status registers of a USB hub controller. A host reaches them through a single-cycle register port. The port takes an address, write data, a write enable and a read enable. Read data comes back one clock after the read enable. Two registers are mapped. The feature register carries a 3-bit power-on delay code. The status/command register carries a configuration-active flag and a soft-reset request.

The block drives two outputs. The first is a power-control enable. It drops as soon as a charging-mode change is signalled and returns after a programmable delay, counted in pulses of a 1 ms tick input. The delay is `(code + 1)` steps of `STEP_TICKS` ticks. The code comes from a nonvolatile override input when that input is nonzero, and from the feature register otherwise. The second output is an upstream-connect enable. It is held low while the configuration-active flag is set.

A serial configuration controller, an EEPROM loader and the charging-mode logic sit outside the block. They reach it through simple strobes: a configuration-mode entry pulse, an EEPROM load pulse with its data byte, and a mode-change pulse. A soft reset requested through the status register runs for a fixed number of cycles and returns every register to its default.

Top module: `hub_cfg_regs`

## Requirements
- R1: The feature register at address 0xF0 resets to 0. Bits 3:1 hold the delay code and are written by the host. Bits 7:4 and bit 0 always read as 0.
- R2: The status register at address 0xF8 reads bit 6 as the soft-reset flag and bit 5 as the configuration-active flag, with all other bits 0. Any other address reads 0 and ignores writes. `rdata_o` shows the addressed register one cycle after `re_i`, and is 0 after a cycle without `re_i`.
- R3: An EEPROM load pulse copies `ee_data_i[3:1]` into the delay code. When it coincides with a host write to 0xF0, the EEPROM value wins.
- R4: The delay code in use is `otp_delay_i` when that input is nonzero, and the feature register code otherwise.
- R5: `pwr_en_o` is 1 after reset. It goes to 0 on the clock edge that samples `mode_chg_i`. It returns to 1 on the edge that samples the `(code+1)*STEP_TICKS`-th `tick_i` pulse after that edge. It does not count a tick sampled on the same edge as the mode change.
- R6: A mode change sampled while a delay is pending restarts the full delay.
- R7: `cfg_enter_i` sets the configuration-active flag (bit 5). Writing 1 to bit 5 of 0xF8 clears it, and writing 0 has no effect. When the set and the clear fall on the same edge, the set wins.
- R8: `upstream_en_o` is 0 whenever the configuration-active flag is 1, and 1 otherwise.
- R9: Writing 1 to bit 6 of 0xF8 starts a soft reset, and writing 0 there has no effect. Bit 6 then reads 1 for exactly `SRST_CYCLES` cycles and clears by itself.
- R10: A soft reset returns the delay code and the configuration-active flag to 0. While it runs, host writes, EEPROM loads and `cfg_enter_i` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Host write data |
| we_i | input | 1 | Host write enable |
| re_i | input | 1 | Host read enable |
| rdata_o | output | 8 | Read data, valid the cycle after `re_i` |
| ee_load_i | input | 1 | EEPROM load strobe for the feature register |
| ee_data_i | input | 8 | EEPROM data byte |
| otp_delay_i | input | 3 | Nonvolatile delay override, 0 means unused |
| cfg_enter_i | input | 1 | Configuration mode entry pulse |
| mode_chg_i | input | 1 | Charging-mode change pulse |
| tick_i | input | 1 | 1 ms time base pulse |
| pwr_en_o | output | 1 | Power-control enable |
| upstream_en_o | output | 1 | Upstream connect enable |

## Verification
The bench builds the block with `STEP_TICKS = 2` and `SRST_CYCLES = 4`. The whole delay range is then 2 to 16 ticks, so every delay code, the override path and a restart in mid-delay can be walked tick by tick. The short soft reset can be watched edge by edge through back-to-back status reads, including writes that land inside its window.

// File: rtl/hub_cfg_pkg.sv
package hub_cfg_pkg;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned ADDR_W   = 8;
  localparam int unsigned CODE_W   = 3;
  localparam int unsigned CODE_LSB = 1;
  localparam int unsigned SRST_BIT = 6;
  localparam int unsigned CFG_BIT  = 5;

  localparam logic [ADDR_W-1:0] FEAT_ADDR = 8'hF0;
  localparam logic [ADDR_W-1:0] STAT_ADDR = 8'hF8;

  localparam logic [DATA_W-1:0] FEAT_MASK = DATA_W'(((1 << CODE_W) - 1) << CODE_LSB);

  function automatic logic [DATA_W-1:0] stat_word(input logic srst, input logic cfg);
    logic [DATA_W-1:0] w;
    w           = '0;
    w[SRST_BIT] = srst;
    w[CFG_BIT]  = cfg;
    return w;
  endfunction
endpackage

// File: rtl/hub_cfg_regfile.sv
module hub_cfg_regfile
  import hub_cfg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic              ee_load_i,
  input  logic [DATA_W-1:0] ee_data_i,
  input  logic              cfg_enter_i,
  input  logic              srst_busy_i,
  output logic              srst_req_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [CODE_W-1:0] code_o,
  output logic              cfg_active_o
);
  logic              feat_hit, stat_hit, clr;
  logic [DATA_W-1:0] feat_q, rd_mux;
  logic              cfg_q;

  assign feat_hit   = (addr_i == FEAT_ADDR);
  assign stat_hit   = (addr_i == STAT_ADDR);
  assign srst_req_o = we_i && stat_hit && wdata_i[SRST_BIT] && !srst_busy_i;
  assign clr        = srst_req_o || srst_busy_i;

  // EEPROM load outranks a host write in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                feat_q <= '0;
    else if (clr)               feat_q <= '0;
    else if (ee_load_i)         feat_q <= ee_data_i & FEAT_MASK;
    else if (we_i && feat_hit)  feat_q <= wdata_i & FEAT_MASK;
  end

  // hardware set outranks host clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                    cfg_q <= 1'b0;
    else if (clr)                                   cfg_q <= 1'b0;
    else if (cfg_enter_i)                           cfg_q <= 1'b1;
    else if (we_i && stat_hit && wdata_i[CFG_BIT])  cfg_q <= 1'b0;
  end

  always_comb begin
    if (feat_hit)      rd_mux = feat_q;
    else if (stat_hit) rd_mux = stat_word(srst_busy_i, cfg_q);
    else               rd_mux = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= rd_mux;
    else           rdata_o <= '0;
  end

  assign code_o       = feat_q[CODE_LSB +: CODE_W];
  assign cfg_active_o = cfg_q;

  a_r1_rsvd_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    re_i && feat_hit |=> (rdata_o[DATA_W-1:CODE_LSB+CODE_W] == '0) && !rdata_o[0]);
  a_r2_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    re_i && !feat_hit && !stat_hit |=> rdata_o == '0);
  a_r2_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> rdata_o == '0);
  a_r3_ee_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ee_load_i && !clr |=> code_o == $past(ee_data_i[CODE_LSB +: CODE_W]));
  a_r7_cfg_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_enter_i && !clr |=> cfg_active_o);
  a_r7_cfg_w0_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_active_o && !clr && !(we_i && stat_hit && wdata_i[CFG_BIT]) |=> cfg_active_o);
  a_r10_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr |=> (code_o == '0) && !cfg_active_o);
endmodule

// File: rtl/hub_cfg_srst.sv
module hub_cfg_srst #(
  parameter int unsigned SRST_CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic busy_o
);
  localparam int unsigned CNT_W = $clog2(SRST_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end else if (req_i) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_W'(SRST_CYCLES - 1);
    end
  end

  assign busy_o = busy_q;

  a_r9_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !busy_o |=> busy_o);
  a_r9_end_on_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(cnt_q) == '0);
  a_r9_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> cnt_q < CNT_W'(SRST_CYCLES));
endmodule

// File: rtl/hub_pwr_delay.sv
module hub_pwr_delay #(
  parameter int unsigned CODE_W     = 3,
  parameter int unsigned STEP_TICKS = 200
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_chg_i,
  input  logic              tick_i,
  input  logic [CODE_W-1:0] otp_code_i,
  input  logic [CODE_W-1:0] reg_code_i,
  output logic              pwr_en_o
);
  localparam int unsigned MAX_CNT = (1 << CODE_W) * STEP_TICKS;
  localparam int unsigned CNT_W   = $clog2(MAX_CNT + 1);

  logic [CODE_W-1:0] sel_code;
  logic [CNT_W-1:0]  load_val, remain_q;
  logic              pending_q, pwr_q;

  // nonzero nonvolatile code overrides the register
  assign sel_code = (otp_code_i != '0) ? otp_code_i : reg_code_i;
  assign load_val = (CNT_W'(sel_code) + CNT_W'(1)) * CNT_W'(STEP_TICKS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwr_q     <= 1'b1;
      pending_q <= 1'b0;
      remain_q  <= '0;
    end else if (mode_chg_i) begin
      pwr_q     <= 1'b0;
      pending_q <= 1'b1;
      remain_q  <= load_val;
    end else if (pending_q && tick_i) begin
      if (remain_q == CNT_W'(1)) begin
        pwr_q     <= 1'b1;
        pending_q <= 1'b0;
      end
      remain_q <= remain_q - 1'b1;
    end
  end

  assign pwr_en_o = pwr_q;

  a_r5_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_chg_i |=> !pwr_en_o);
  a_r5_rise_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwr_en_o) |-> $past(tick_i) && !$past(mode_chg_i));
  a_r5_stay_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_en_o && !mode_chg_i |=> pwr_en_o);
  a_r6_hold_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_en_o && !tick_i |=> !pwr_en_o);
endmodule

// File: rtl/hub_cfg_regs.sv
module hub_cfg_regs
  import hub_cfg_pkg::*;
#(
  parameter int unsigned STEP_TICKS  = 200,
  parameter int unsigned SRST_CYCLES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  input  logic              re_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              ee_load_i,
  input  logic [DATA_W-1:0] ee_data_i,
  input  logic [CODE_W-1:0] otp_delay_i,
  input  logic              cfg_enter_i,
  input  logic              mode_chg_i,
  input  logic              tick_i,
  output logic              pwr_en_o,
  output logic              upstream_en_o
);
  logic              srst_req, srst_busy, cfg_active;
  logic [CODE_W-1:0] reg_code;

  hub_cfg_regfile u_regfile (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .addr_i       (addr_i),
    .wdata_i      (wdata_i),
    .we_i         (we_i),
    .re_i         (re_i),
    .ee_load_i    (ee_load_i),
    .ee_data_i    (ee_data_i),
    .cfg_enter_i  (cfg_enter_i),
    .srst_busy_i  (srst_busy),
    .srst_req_o   (srst_req),
    .rdata_o      (rdata_o),
    .code_o       (reg_code),
    .cfg_active_o (cfg_active)
  );

  hub_cfg_srst #(.SRST_CYCLES(SRST_CYCLES)) u_srst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (srst_req),
    .busy_o (srst_busy)
  );

  hub_pwr_delay #(.CODE_W(CODE_W), .STEP_TICKS(STEP_TICKS)) u_pwr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_chg_i (mode_chg_i),
    .tick_i     (tick_i),
    .otp_code_i (otp_delay_i),
    .reg_code_i (reg_code),
    .pwr_en_o   (pwr_en_o)
  );

  assign upstream_en_o = !cfg_active;

  a_r8_no_connect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_enter_i && !srst_busy && !srst_req |=> !upstream_en_o);
  a_r10_quiet_during_srst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_busy |=> upstream_en_o);
endmodule

// File: tb/hub_cfg_regs_bench.sv
module hub_cfg_regs_bench;
  localparam int unsigned CLK_PERIOD  = 10;
  localparam int unsigned STEP_TICKS  = 2;
  localparam int unsigned SRST_CYCLES = 4;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] addr_i = '0, wdata_i = '0, ee_data_i = '0;
  logic       we_i = 0, re_i = 0, ee_load_i = 0, cfg_enter_i = 0, mode_chg_i = 0, tick_i = 0;
  logic [2:0] otp_delay_i = '0;
  logic [7:0] rdata_o;
  logic       pwr_en_o, upstream_en_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hub_cfg_regs #(.STEP_TICKS(STEP_TICKS), .SRST_CYCLES(SRST_CYCLES)) u_hub_cfg_regs (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i), .we_i(we_i),
    .re_i(re_i), .rdata_o(rdata_o), .ee_load_i(ee_load_i), .ee_data_i(ee_data_i),
    .otp_delay_i(otp_delay_i), .cfg_enter_i(cfg_enter_i), .mode_chg_i(mode_chg_i),
    .tick_i(tick_i), .pwr_en_o(pwr_en_o), .upstream_en_o(upstream_en_o)
  );

  function automatic logic [7:0] feat_exp(input logic [2:0] code);
    return {4'b0, code, 1'b0};
  endfunction
  function automatic logic [7:0] stat_exp(input logic srst, input logic cfg);
    return {1'b0, srst, cfg, 5'b0};
  endfunction
  function automatic int delay_ticks(input logic [2:0] otp, input logic [2:0] code);
    return ((otp != 0) ? int'(otp) + 1 : int'(code) + 1) * STEP_TICKS;
  endfunction

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // all tasks enter and leave at a falling edge
  task automatic host_write(input logic [7:0] a, input logic [7:0] d);
    addr_i = a; wdata_i = d; we_i = 1;
    @(negedge clk);
    we_i = 0;
  endtask
  task automatic host_read(input logic [7:0] a, output logic [7:0] d);
    addr_i = a; re_i = 1;
    @(negedge clk);
    re_i = 0; d = rdata_o;
  endtask
  task automatic tick();
    tick_i = 1; @(negedge clk); tick_i = 0;
  endtask
  task automatic mode_chg();
    mode_chg_i = 1; @(negedge clk); mode_chg_i = 0;
  endtask
  task automatic pulse_cfg();
    cfg_enter_i = 1; @(negedge clk); cfg_enter_i = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog got=timeout exp=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    logic [2:0] m_code;
    logic       m_cfg;
    int         n;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);

    // reset state
    check("R5 reset pwr_en", {7'b0, pwr_en_o}, 8'h01);
    check("R8 reset upstream_en", {7'b0, upstream_en_o}, 8'h01);
    check("R2 idle rdata", rdata_o, 8'h00);
    host_read(8'hF0, rd); check("R1 reset feature", rd, 8'h00);
    host_read(8'hF8, rd); check("R2 reset status", rd, 8'h00);

    // R1 masking
    host_write(8'hF0, 8'hFF);
    host_read(8'hF0, rd); check("R1 write ff", rd, feat_exp(3'd7));
    host_write(8'hF0, 8'h0A);
    host_read(8'hF0, rd); check("R1 write 0a", rd, feat_exp(3'd5));
    // R2 unmapped
    host_write(8'h10, 8'h55);
    host_read(8'h10, rd); check("R2 unmapped read", rd, 8'h00);
    host_read(8'hF0, rd); check("R2 unmapped write ignored", rd, feat_exp(3'd5));
    @(negedge clk);
    check("R2 zero after idle", rdata_o, 8'h00);
    host_write(8'hF8, 8'h9F);
    host_read(8'hF8, rd); check("R2 status rsvd", rd, 8'h00);

    // R7 / R8
    pulse_cfg();
    check("R8 upstream low", {7'b0, upstream_en_o}, 8'h00);
    host_read(8'hF8, rd); check("R7 cfg set", rd, stat_exp(0, 1));
    host_write(8'hF8, 8'h00);
    host_read(8'hF8, rd); check("R7 write0 no effect", rd, stat_exp(0, 1));
    cfg_enter_i = 1; host_write(8'hF8, 8'h20); cfg_enter_i = 0;
    host_read(8'hF8, rd); check("R7 set beats clear", rd, stat_exp(0, 1));
    host_write(8'hF8, 8'h20);
    host_read(8'hF8, rd); check("R7 w1c", rd, stat_exp(0, 0));
    check("R8 upstream high", {7'b0, upstream_en_o}, 8'h01);

    // R3 EEPROM priority
    ee_load_i = 1; ee_data_i = 8'hF4; host_write(8'hF0, 8'h0E); ee_load_i = 0;
    host_read(8'hF0, rd); check("R3 ee beats host", rd, feat_exp(3'd2));

    // R4 / R5 register code
    host_write(8'hF0, feat_exp(3'd3));
    otp_delay_i = 3'd0;
    mode_chg();
    check("R5 pwr drop", {7'b0, pwr_en_o}, 8'h00);
    n = delay_ticks(3'd0, 3'd3);
    for (int i = 0; i < n - 1; i++) tick();
    check("R5 pwr off before last tick", {7'b0, pwr_en_o}, 8'h00);
    tick();
    check("R5 pwr on after delay", {7'b0, pwr_en_o}, 8'h01);

    // R4 override
    otp_delay_i = 3'd5;
    mode_chg();
    n = delay_ticks(3'd5, 3'd3);
    for (int i = 0; i < n - 1; i++) tick();
    check("R4 otp off before last", {7'b0, pwr_en_o}, 8'h00);
    tick();
    check("R4 otp on after delay", {7'b0, pwr_en_o}, 8'h01);
    otp_delay_i = 3'd0;

    // R6 restart, mode change with tick in same cycle
    host_write(8'hF0, 8'h00);
    mode_chg();
    tick();
    mode_chg_i = 1; tick_i = 1; @(negedge clk); mode_chg_i = 0; tick_i = 0;
    tick();
    check("R6 restart still off", {7'b0, pwr_en_o}, 8'h00);
    tick();
    check("R6 restart on", {7'b0, pwr_en_o}, 8'h01);

    // R9 / R10 soft reset
    host_write(8'hF0, 8'h0E);
    pulse_cfg();
    host_write(8'hF8, 8'h00);
    host_read(8'hF8, rd); check("R9 write0 no reset", rd, stat_exp(0, 1));
    host_write(8'hF8, 8'h40);
    n = 0;
    for (int i = 0; i < SRST_CYCLES + 2; i++) begin
      host_read(8'hF8, rd);
      if (rd[6]) n++;
    end
    check("R9 busy length", 8'(n), 8'(SRST_CYCLES));
    check("R9 self clear", rd, stat_exp(0, 0));
    host_read(8'hF0, rd); check("R10 feature default", rd, 8'h00);
    check("R10 upstream restored", {7'b0, upstream_en_o}, 8'h01);
    host_write(8'hF8, 8'h40);
    host_write(8'hF0, 8'h0E);
    ee_load_i = 1; ee_data_i = 8'h0C; cfg_enter_i = 1;
    @(negedge clk);
    ee_load_i = 0; cfg_enter_i = 0;
    repeat (SRST_CYCLES) @(negedge clk);
    host_read(8'hF0, rd); check("R10 writes ignored in reset", rd, 8'h00);
    host_read(8'hF8, rd); check("R10 cfg ignored in reset", rd, 8'h00);

    // random register traffic against a model
    m_code = 3'd0; m_cfg = 1'b0;
    begin
      logic [7:0] exp_rd;
      bit         have_exp = 0;
      for (int i = 0; i < 400; i++) begin
        if (have_exp) check("R2 random read", rdata_o, exp_rd);
        check("R8 random upstream", {7'b0, upstream_en_o}, {7'b0, !m_cfg});
        case ($urandom_range(0, 3))
          0:       addr_i = 8'hF0;
          1:       addr_i = 8'hF8;
          default: addr_i = 8'($urandom);
        endcase
        wdata_i = 8'($urandom);
        if (addr_i == 8'hF8) wdata_i[6] = 1'b0;
        we_i        = ($urandom_range(0, 2) == 0);
        re_i        = ($urandom_range(0, 1) == 0);
        ee_load_i   = ($urandom_range(0, 7) == 0);
        ee_data_i   = 8'($urandom);
        cfg_enter_i = ($urandom_range(0, 5) == 0);
        if (!re_i)                exp_rd = 8'h00;
        else if (addr_i == 8'hF0) exp_rd = feat_exp(m_code);
        else if (addr_i == 8'hF8) exp_rd = stat_exp(1'b0, m_cfg);
        else                      exp_rd = 8'h00;
        have_exp = 1;
        if (ee_load_i)                          m_code = ee_data_i[3:1];
        else if (we_i && addr_i == 8'hF0)       m_code = wdata_i[3:1];
        if (cfg_enter_i)                        m_cfg = 1'b1;
        else if (we_i && addr_i == 8'hF8 && wdata_i[5]) m_cfg = 1'b0;
        @(negedge clk);
      end
      we_i = 0; re_i = 0; ee_load_i = 0; cfg_enter_i = 0;
      check("R2 random last read", rdata_o, exp_rd);
      host_read(8'hF0, rd); check("R3 random final code", rd, feat_exp(m_code));
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule